// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. The host writes a character into a holding register. The block moves it into a separate shift register and sends it on a single line as a framed character. The frame is a low start bit, then 7 or 8 data bits sent low bit first, then an optional parity or multiprocessor bit, then one or two high stop bits. Because the holding register and the shift register are separate, the host can write the next character while the current one is still going out.

The timing of each bit comes from an external one-clock enable pulse at the bit rate. The block does not divide the clock itself. Two flags report progress to the host: buffer-empty and transmit-end. The block samples buffer-empty when the first stop bit begins, and the result decides what happens next. If a character is waiting, it is loaded at that point and its start bit follows the last stop bit directly. If nothing is waiting, the transmit-end flag is set and the line stays high. Each flag drives a level interrupt through its own enable bit.

Top module: `sertx_top`

## Requirements
- R1: After reset, or during any cycle in which `tx_en` is 0, `txd` is 1, `buf_empty` is 1 and `tx_end` is 1.
- R2: A write (`wr_en`=1 with `tx_en`=1) stores `wr_data`. From the next cycle it reads 0 on both `buf_empty` and `tx_end`.
- R3: When `buf_empty` is 0 and the line is idle, the next bit-rate pulse copies the holding register into the shift register and sets `buf_empty` to 1. The start bit begins on that same pulse.
- R4: A frame is sent in this order: start bit (0), data least significant bit first, the optional bit, then the stop bits (1). Each bit lasts one bit-rate pulse period, and `txd` changes only on a bit-rate pulse.
- R5: When `char7`=1, 7 data bits (`wr_data[6:0]`) are sent. Otherwise 8 bits are sent.
- R6: `opt_mode` selects the optional bit:
  - 2'b00: no optional bit.
  - 2'b01: even parity (the data bits plus this bit hold an even number of ones).
  - 2'b10: odd parity.
  - 2'b11: the value of `mp_bit`.
- R7: When `two_stop`=1, two stop bits are sent. Otherwise one stop bit is sent.
- R8: If `buf_empty` is 0 when the first stop bit begins, the waiting character is loaded at that pulse and `buf_empty` returns to 1. Its start bit directly follows the last stop bit, with no idle bit between.
- R9: If `buf_empty` is 1 when the first stop bit begins, `tx_end` is set to 1 at that pulse. After the stop bits, `txd` stays 1 until the next start bit.
- R10: `irq_empty` equals `buf_empty` AND `irq_empty_en`. `irq_end` equals `tx_end` AND `irq_end_en`.
- R11: While `tx_en` is 0, writes are ignored and no frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; 0 holds the block idle |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| char7 | input | 1 | 1 selects 7-bit characters |
| opt_mode | input | 2 | Optional bit: none, even, odd, multiprocessor |
| mp_bit | input | 1 | Value of the multiprocessor bit |
| two_stop | input | 1 | 1 selects two stop bits |
| irq_empty_en | input | 1 | Enable for the buffer-empty interrupt |
| irq_end_en | input | 1 | Enable for the transmit-end interrupt |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register is free |
| tx_end | output | 1 | Transmission finished, line is at mark |
| irq_empty | output | 1 | Buffer-empty interrupt level |
| irq_end | output | 1 | Transmit-end interrupt level |

## Verification
The bench queues characters written just after the previous load. This tests the decision at the first stop bit: a design that sampled the flag too late, or ignored it, would insert an idle bit between frames, and the gap check would catch it. The bench sends a frame in every parity mode with both stop lengths and in 7-bit mode. A wrong parity sense, a wrong bit order or an eighth bit leaking into a 7-bit frame each shows up as a bit mismatch at a known position. Transmit-end is checked after each drained burst, and its interrupt is checked with the enable both on and off. Writes made while the transmitter is disabled must leave both flags set and the line at mark. A design that accepted them would later start a frame that nobody queued.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
package sertx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_STOP1, ST_STOP2
    } tx_state_t;

    typedef enum logic [1:0] {
        OPT_NONE = 2'b00,
        OPT_EVEN = 2'b01,
        OPT_ODD  = 2'b10,
        OPT_MP   = 2'b11
    } opt_mode_t;
endpackage

// File: rtl/sertx_frame_build.sv
// Builds the shift payload (data bits plus the optional bit) and the count
// of payload bits from the character and the format controls.
// Assumes: DATA_W >= 2; the short character mode drops the top data bit.
module sertx_frame_build #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 2)
) (
    input  logic [DATA_W-1:0] data,
    input  logic              short_char,
    input  logic [1:0]        opt_sel,
    input  logic              mp_val,
    output logic [DATA_W:0]   payload,
    output logic [CNT_W-1:0]  nbits
);
    import sertx_pkg::*;

    logic [DATA_W-1:0] masked;
    logic [CNT_W-1:0]  used;
    logic              has_opt;
    logic              opt_bit;

    // Mask the character, pick the optional bit and place it after the data.
    always_comb begin
        used    = short_char ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
        masked  = short_char ? {1'b0, data[DATA_W-2:0]} : data;
        has_opt = 1'b1;
        opt_bit = 1'b0;
        case (opt_mode_t'(opt_sel))
            OPT_NONE: has_opt = 1'b0;
            OPT_EVEN: opt_bit = ^masked;
            OPT_ODD:  opt_bit = ~^masked;
            default:  opt_bit = mp_val;
        endcase
        payload = {1'b0, masked};
        if (has_opt) payload[used] = opt_bit;
        nbits = used + {{(CNT_W-1){1'b0}}, has_opt};
    end
endmodule

// File: rtl/sertx_shifter.sv
// Frame sequencer and shift register. Advances one bit per bit-rate pulse,
// loads a waiting character from idle or at the start of the first stop bit,
// and reports load and transmit-end events to the flag logic.
// Assumes: format inputs stay stable while a frame is in flight.
module sertx_shifter #(
    parameter int DATA_W = 8,
    localparam int SH_W  = DATA_W + 1,
    localparam int CNT_W = $clog2(DATA_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             bit_tick,
    input  logic             buf_full,
    input  logic [SH_W-1:0]  payload,
    input  logic [CNT_W-1:0] nbits,
    input  logic             two_stop,
    output logic             txd,
    output logic             load,
    output logic             end_set
);
    import sertx_pkg::*;

    tx_state_t        st;
    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             txd_q;
    logic             last_bit;

    // Payload exhausted: this pulse begins the first stop bit.
    assign last_bit = (st == ST_DATA) && (cnt == '0);
    assign load     = rst_n && tx_en && bit_tick && buf_full &&
                      ((st == ST_IDLE) || last_bit);
    assign end_set  = rst_n && tx_en && bit_tick && !buf_full && last_bit;
    assign txd      = txd_q;

    // Bit sequencer: one state step per bit-rate pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            st    <= ST_IDLE;
            sh    <= '0;
            cnt   <= '0;
            pend  <= 1'b0;
            txd_q <= 1'b1;
        end else if (bit_tick) begin
            case (st)
                ST_IDLE: if (buf_full) begin
                    sh    <= payload;
                    cnt   <= nbits;
                    txd_q <= 1'b0;
                    st    <= ST_START;
                end
                ST_START: begin
                    txd_q <= sh[0];
                    sh    <= sh >> 1;
                    cnt   <= cnt - 1'b1;
                    st    <= ST_DATA;
                end
                ST_DATA: if (cnt == '0) begin
                    txd_q <= 1'b1;
                    st    <= ST_STOP1;
                    if (buf_full) begin
                        sh   <= payload;
                        cnt  <= nbits;
                        pend <= 1'b1;
                    end
                end else begin
                    txd_q <= sh[0];
                    sh    <= sh >> 1;
                    cnt   <= cnt - 1'b1;
                end
                default: if (st == ST_STOP1 && two_stop) begin
                    st <= ST_STOP2;
                end else if (pend) begin
                    txd_q <= 1'b0;
                    pend  <= 1'b0;
                    st    <= ST_START;
                end else begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // R4: the line moves only on a bit-rate pulse.
    p_txd_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick) |=> $stable(txd));
endmodule

// File: rtl/sertx_top.sv
// Double-buffered asynchronous serial transmitter: holding register, flag
// logic and interrupt levels around the frame builder and the sequencer.
// Assumes: bit_tick is a single-cycle pulse; synchronous active-low reset.
module sertx_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              char7,
    input  logic [1:0]        opt_mode,
    input  logic              mp_bit,
    input  logic              two_stop,
    input  logic              irq_empty_en,
    input  logic              irq_end_en,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_end,
    output logic              irq_empty,
    output logic              irq_end
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    logic [DATA_W-1:0] hold_q;
    logic              empty_q;
    logic              end_q;
    logic [DATA_W:0]   payload;
    logic [CNT_W-1:0]  nbits;
    logic              load;
    logic              end_set;
    logic              wr_ok;

    assign wr_ok = wr_en && tx_en;

    // Holding register: captures host writes while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else if (wr_ok) hold_q <= wr_data;
    end

    // Flags: a write clears both and wins over a same-cycle load or end event.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            empty_q <= 1'b1;
            end_q   <= 1'b1;
        end else if (wr_ok) begin
            empty_q <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            if (load)    empty_q <= 1'b1;
            if (end_set) end_q   <= 1'b1;
        end
    end

    sertx_frame_build #(.DATA_W(DATA_W)) u_build (
        .data       (hold_q),
        .short_char (char7),
        .opt_sel    (opt_mode),
        .mp_val     (mp_bit),
        .payload    (payload),
        .nbits      (nbits)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .bit_tick (bit_tick),
        .buf_full (!empty_q),
        .payload  (payload),
        .nbits    (nbits),
        .two_stop (two_stop),
        .txd      (txd),
        .load     (load),
        .end_set  (end_set)
    );

    assign buf_empty = empty_q;
    assign tx_end    = end_q;
    assign irq_empty = empty_q && irq_empty_en;
    assign irq_end   = end_q && irq_end_en;

    // R2: an accepted write clears both flags.
    p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (!buf_empty && !tx_end));
    // R3: a load with no competing write frees the buffer.
    p_load_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> buf_empty);
    // R9: while transmit-end is set the line is at mark.
    p_end_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> txd);
endmodule

// File: tb/sertx_top_bench.sv
`timescale 1ns/1ps
module sertx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       char7 = 1'b0;
    logic [1:0] opt_mode = 2'b00;
    logic       mp_bit = 1'b0;
    logic       two_stop = 1'b0;
    logic       irq_empty_en = 1'b1;
    logic       irq_end_en = 1'b1;
    logic       txd, buf_empty, tx_end, irq_empty, irq_end;

    int errors = 0;
    int checks = 0;
    bit bitq[$];
    int lenq[$];
    bit gapq[$];
    int rem = 0;
    bit just_done = 1'b0;
    int tick_cnt = 0;

    always #2.5 clk = ~clk;

    sertx_top u_sertx_top (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_data(wr_data), .char7(char7), .opt_mode(opt_mode),
        .mp_bit(mp_bit), .two_stop(two_stop), .irq_empty_en(irq_empty_en),
        .irq_end_en(irq_end_en), .txd(txd), .buf_empty(buf_empty),
        .tx_end(tx_end), .irq_empty(irq_empty), .irq_end(irq_end)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: after every edge that saw a pulse, compare the line with the scoreboard.
    always @(negedge clk) begin
        bit was_tick;
        was_tick = bit_tick;
        tick_cnt = (tick_cnt + 1) % 4;
        bit_tick = (tick_cnt == 0);
        if (was_tick && rst_n) begin
            if (rem > 0) begin
                check("R4 frame bit", txd, bitq.pop_front());
                rem--;
                just_done = (rem == 0);
            end else if (lenq.size() > 0) begin
                if (txd == 1'b0) begin
                    bit g;
                    g = gapq.pop_front();
                    if (g) check("R8 gapless start", just_done, 1);
                    rem = lenq.pop_front();
                    check("R4 start bit", txd, bitq.pop_front());
                    rem--;
                end else if (gapq[0] && just_done) begin
                    check("R8 idle gap before queued frame", txd, 0);
                    gapq[0] = 1'b0;
                end
                just_done = 1'b0;
            end else begin
                check("R9 mark state", txd, 1);
                just_done = 1'b0;
            end
        end
    end

    // Driver: queue the expected frame, then write the character.
    task automatic send(logic [7:0] d, bit gapless);
        int n;
        bit p;
        n = char7 ? 7 : 8;
        p = 1'b0;
        bitq.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            bitq.push_back(d[i]);
            p ^= d[i];
        end
        case (opt_mode)
            2'b01: bitq.push_back(p);
            2'b10: bitq.push_back(~p);
            2'b11: bitq.push_back(mp_bit);
            default: ;
        endcase
        bitq.push_back(1'b1);
        if (two_stop) bitq.push_back(1'b1);
        lenq.push_back(1 + n + (opt_mode != 2'b00 ? 1 : 0) + (two_stop ? 2 : 1));
        gapq.push_back(gapless);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 empty cleared", buf_empty, 0);
        check("R2 end cleared", tx_end, 0);
    endtask

    task automatic drain();
        while (bitq.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // Send two characters; the second is written as soon as the first loads.
    task automatic pair(logic [7:0] a, logic [7:0] b);
        send(a, 1'b0);
        wait (buf_empty == 1'b1);
        @(negedge clk);
        check("R10 irq_empty follows empty", irq_empty, 1);
        send(b, 1'b1);
        drain();
        check("R9 end set after drain", tx_end, 1);
        check("R10 irq_end with enable", irq_end, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 txd at reset", txd, 1);
        check("R1 empty at reset", buf_empty, 1);
        check("R1 end at reset", tx_end, 1);
        rst_n = 1'b1;
        tx_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 irq_empty idle", irq_empty, 1);
        check("R10 irq_end idle", irq_end, 1);

        // R5 R6: 8 bits, no optional bit, single stop.
        send(8'hA5, 1'b0);
        wait (buf_empty == 1'b1);
        @(negedge clk);
        check("R3 empty set at load", buf_empty, 1);
        drain();
        check("R9 end after single frame", tx_end, 1);

        // R6 even parity, back-to-back (R8).
        opt_mode = 2'b01;
        pair(8'h3C, 8'h3D);
        // R6 odd parity, R7 two stops, back-to-back.
        opt_mode = 2'b10;
        two_stop = 1'b1;
        pair(8'h81, 8'h7F);
        // R5 7-bit with multiprocessor bit (R6), top bit must be dropped.
        char7 = 1'b1;
        opt_mode = 2'b11;
        mp_bit = 1'b1;
        send(8'hFF, 1'b0);
        drain();
        mp_bit = 1'b0;
        two_stop = 1'b0;
        pair(8'h95, 8'h2A);

        // R10: transmit-end interrupt masked.
        irq_end_en = 1'b0;
        @(negedge clk);
        check("R10 irq_end masked", irq_end, 0);
        check("R10 end still set", tx_end, 1);

        // R11 and R1: disabled transmitter ignores writes.
        tx_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R11 empty kept while disabled", buf_empty, 1);
        check("R1 end kept while disabled", tx_end, 1);
        check("R1 txd at mark while disabled", txd, 1);
        tx_en = 1'b1;
        repeat (40) @(negedge clk);
        check("R11 no frame from ignored write", buf_empty, 1);
        check("R11 line idle after enable", txd, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule